// File: doc/BRIEF.md
# Connection-Control Instruction Sequencer

This block runs the connection-control instructions of a script-driven SCSI controller. These instructions are Reselect, Wait Select, Disconnect and Set. A one-cycle `start` strobe hands the block a decoded instruction. The instruction carries an opcode, a destination ID, three control bits for Set, and a jump address. The strobe also hands over the current script pointer, which is the address of the next sequential instruction. The block then does one of two things:

- It finishes at once.
- It waits on bus status inputs for an event that settles the outcome.

Either way it ends by issuing a one-cycle fetch strobe. The strobe carries the address the instruction fetch unit reads next.

The next-fetch address depends on which event comes first. During Reselect, winning arbitration moves on to the script pointer at once, without waiting for the reselection to finish. If the device is selected or reselected by another device first, it branches to the jump address. During Wait Select, the three events lead to different addresses:

- Being selected leads to the script pointer.
- Being reselected leads to the jump address.
- A CPU abort leads to the jump address.

When the device is selected or reselected, it also reports an initiator/target mode change. The bus phase engine, the arbitration logic and the fetch memory all sit outside this block.

Top module: `conn_io_sequencer`

## Requirements
- R1: Opcode 2'b00 (Reselect) puts the block into an arbitration wait one cycle after `start`. During that wait, `arbReq` and `busy` are high and `targetId` equals the `destId` sampled at `start`. The wait lasts until an event arrives.
- R2: During the Reselect wait, an edge with `arbWon` high and neither `selected` nor `reselected` high ends the instruction. After that edge, `fetchAddr` equals the `scriptPtr` sampled at `start`, `fetchStb` and `done` are high, and `busDrive` is high.
- R3: During the Reselect wait, an edge with `selected` or `reselected` high ends the instruction with `fetchAddr` equal to the sampled `jumpAddr`. This holds even when `arbWon` is high on the same edge, and `busDrive` stays unchanged.
- R4: Being selected produces a one-cycle `modeUpd` pulse with `modeTarget`=1 (target). Being reselected without being selected produces a `modeUpd` pulse with `modeTarget`=0 (initiator). Selected takes priority when both are high.
- R5: Opcode 2'b01 (Disconnect) clears `latchAck`, `latchAtn` and `busDrive` on the `start` edge. It fetches from `scriptPtr` on that same edge.
- R6: Opcode 2'b10 (Wait Select) waits until an event arrives. Being selected fetches from the sampled `scriptPtr`. Being reselected without being selected fetches from the sampled `jumpAddr`. `arbWon` has no effect during this wait.
- R7: During the Wait Select wait, `cpuAbort` takes priority over both selection inputs. It fetches from the sampled `jumpAddr` and produces no `modeUpd` pulse.
- R8: Opcode 2'b11 (Set) ORs `setAck` into `latchAck` and `setAtn` into `latchAtn`. If `setTarget` is high, it also sets `modeTarget`=1 with a `modeUpd` pulse. It fetches from `scriptPtr` on the `start` edge.
- R9: `fetchStb` and `done` are high for exactly one cycle per instruction. A `start` that arrives while `busy` is high is ignored.
- R10: When `rstN` is low on a clock edge, the block returns to idle and clears `fetchStb`, `done`, `modeUpd`, `arbReq`, `busy`, `busDrive`, `latchAck`, `latchAtn` and `modeTarget` (initiator).
- R11: While idle, the inputs `arbWon`, `selected`, `reselected` and `cpuAbort` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch the presented instruction |
| opcode | input | 2 | 00 Reselect, 01 Disconnect, 10 Wait Select, 11 Set |
| destId | input | ID_W | Device ID to reselect |
| setAck | input | 1 | Set: raise the ACK latch bit |
| setAtn | input | 1 | Set: raise the ATN latch bit |
| setTarget | input | 1 | Set: switch to target mode |
| jumpAddr | input | ADDR_W | Branch address carried by the instruction |
| scriptPtr | input | ADDR_W | Address of the next sequential instruction |
| arbWon | input | 1 | Arbitration won |
| selected | input | 1 | Selected by another device |
| reselected | input | 1 | Reselected by another device |
| cpuAbort | input | 1 | CPU abort request for Wait Select |
| arbReq | output | 1 | Arbitration request |
| busy | output | 1 | An instruction is waiting on an event |
| targetId | output | ID_W | ID being reselected |
| fetchAddr | output | ADDR_W | Next fetch address |
| fetchStb | output | 1 | One-cycle fetch request |
| done | output | 1 | Instruction complete |
| modeUpd | output | 1 | Mode value is being updated |
| modeTarget | output | 1 | 1 = target, 0 = initiator |
| latchAck | output | 1 | Output control latch ACK bit |
| latchAtn | output | 1 | Output control latch ATN bit |
| busDrive | output | 1 | Block drives the bus after winning arbitration |

## Verification
The bench builds the block with its defaults: 32-bit addresses and 4-bit IDs. Random full-width jump addresses and script pointers make any mix-up between the two fetch sources visible. Every one of the 16 destination IDs can reach `targetId`. Random wait lengths and random combinations of same-cycle events cover the priority orders: selection over arbitration, abort over selection, and selected over reselected.

// File: rtl/conn_io_pkg.sv
package conn_io_pkg;

  typedef enum logic [1:0] {
    OP_RESEL = 2'b00,
    OP_DISC  = 2'b01,
    OP_WSEL  = 2'b10,
    OP_SET   = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARB  = 2'b01,
    ST_WSEL = 2'b10
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // save instruction fields
    logic fetch;       // issue a fetch this edge
    logic useJump;     // fetch source: jump address
    logic useLive;     // fetch source: live script pointer
    logic modeWr;      // update mode
    logic modeVal;     // 1 = target
    logic connect;     // start driving bus
    logic disconnect;  // release all bus outputs
    logic applySet;    // apply Set instruction bits
  } dpCtl_t;

endpackage

// File: rtl/conn_io_ctrl.sv
module conn_io_ctrl
  import conn_io_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opcode,
  input  logic       arbWon,
  input  logic       selected,
  input  logic       reselected,
  input  logic       cpuAbort,
  output dpCtl_t     ctl,
  output logic       arbReq,
  output logic       busy
);

  state_e stateQ, stateD;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          unique case (opcode_e'(opcode))
            OP_RESEL: begin
              ctl.capture = 1'b1;
              stateD      = ST_ARB;
            end
            OP_WSEL: begin
              ctl.capture = 1'b1;
              stateD      = ST_WSEL;
            end
            OP_DISC: begin
              ctl.fetch      = 1'b1;
              ctl.useLive    = 1'b1;
              ctl.disconnect = 1'b1;
            end
            OP_SET: begin
              ctl.fetch    = 1'b1;
              ctl.useLive  = 1'b1;
              ctl.applySet = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_ARB: begin
        // being selected/reselected beats arbitration
        if (selected || reselected) begin
          ctl.fetch   = 1'b1;
          ctl.useJump = 1'b1;
          ctl.modeWr  = 1'b1;
          ctl.modeVal = selected;
          stateD      = ST_IDLE;
        end else if (arbWon) begin
          ctl.fetch   = 1'b1;
          ctl.connect = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      ST_WSEL: begin
        if (cpuAbort) begin
          ctl.fetch   = 1'b1;
          ctl.useJump = 1'b1;
          stateD      = ST_IDLE;
        end else if (selected) begin
          ctl.fetch   = 1'b1;
          ctl.modeWr  = 1'b1;
          ctl.modeVal = 1'b1;
          stateD      = ST_IDLE;
        end else if (reselected) begin
          ctl.fetch   = 1'b1;
          ctl.useJump = 1'b1;
          ctl.modeWr  = 1'b1;
          ctl.modeVal = 1'b0;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign arbReq = (stateQ == ST_ARB);
  assign busy   = (stateQ != ST_IDLE);

  // R1: arbitration request persists until an event arrives
  assert_arb_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ARB && !arbWon && !selected && !reselected) |=> (stateQ == ST_ARB));

endmodule

// File: rtl/conn_io_dp.sv
module conn_io_dp
  import conn_io_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ID_W-1:0]   destId,
  input  logic              setAck,
  input  logic              setAtn,
  input  logic              setTarget,
  input  logic [ADDR_W-1:0] jumpAddr,
  input  logic [ADDR_W-1:0] scriptPtr,
  output logic [ID_W-1:0]   targetId,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchStb,
  output logic              done,
  output logic              modeUpd,
  output logic              modeTarget,
  output logic              latchAck,
  output logic              latchAtn,
  output logic              busDrive,
  output logic [ADDR_W-1:0] savedJump
);

  logic [ADDR_W-1:0] savedPtrQ, savedJumpQ, fetchAddrQ, nextAddr;
  logic [ID_W-1:0]   targetIdQ;
  logic fetchStbQ, doneQ, modeUpdQ, modeQ, ackQ, atnQ, driveQ;

  always_comb begin
    if (ctl.useJump)      nextAddr = savedJumpQ;
    else if (ctl.useLive) nextAddr = scriptPtr;
    else                  nextAddr = savedPtrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPtrQ  <= '0;
      savedJumpQ <= '0;
      targetIdQ  <= '0;
      fetchAddrQ <= '0;
      fetchStbQ  <= 1'b0;
      doneQ      <= 1'b0;
      modeUpdQ   <= 1'b0;
      modeQ      <= 1'b0;
      ackQ       <= 1'b0;
      atnQ       <= 1'b0;
      driveQ     <= 1'b0;
    end else begin
      fetchStbQ <= ctl.fetch;
      doneQ     <= ctl.fetch;
      modeUpdQ  <= ctl.modeWr || (ctl.applySet && setTarget);
      if (ctl.capture) begin
        savedPtrQ  <= scriptPtr;
        savedJumpQ <= jumpAddr;
        targetIdQ  <= destId;
      end
      if (ctl.fetch) fetchAddrQ <= nextAddr;
      if (ctl.modeWr) modeQ <= ctl.modeVal;
      else if (ctl.applySet && setTarget) modeQ <= 1'b1;
      if (ctl.disconnect) begin
        ackQ   <= 1'b0;
        atnQ   <= 1'b0;
        driveQ <= 1'b0;
      end else begin
        if (ctl.applySet) begin
          ackQ <= ackQ | setAck;
          atnQ <= atnQ | setAtn;
        end
        if (ctl.connect) driveQ <= 1'b1;
      end
    end
  end

  assign targetId   = targetIdQ;
  assign fetchAddr  = fetchAddrQ;
  assign fetchStb   = fetchStbQ;
  assign done       = doneQ;
  assign modeUpd    = modeUpdQ;
  assign modeTarget = modeQ;
  assign latchAck   = ackQ;
  assign latchAtn   = atnQ;
  assign busDrive   = driveQ;
  assign savedJump  = savedJumpQ;

  // R9: fetch strobe lasts a single cycle
  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    fetchStbQ |=> !fetchStbQ);

  // R5: disconnect leaves every bus output low
  assert_disc_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.disconnect |=> (!ackQ && !atnQ && !driveQ));

endmodule

// File: rtl/conn_io_sequencer.sv
module conn_io_sequencer
  import conn_io_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic [ID_W-1:0]   destId,
  input  logic              setAck,
  input  logic              setAtn,
  input  logic              setTarget,
  input  logic [ADDR_W-1:0] jumpAddr,
  input  logic [ADDR_W-1:0] scriptPtr,
  input  logic              arbWon,
  input  logic              selected,
  input  logic              reselected,
  input  logic              cpuAbort,
  output logic              arbReq,
  output logic              busy,
  output logic [ID_W-1:0]   targetId,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchStb,
  output logic              done,
  output logic              modeUpd,
  output logic              modeTarget,
  output logic              latchAck,
  output logic              latchAtn,
  output logic              busDrive
);

  dpCtl_t            ctl;
  logic [ADDR_W-1:0] savedJump;

  conn_io_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .arbWon(arbWon), .selected(selected), .reselected(reselected),
    .cpuAbort(cpuAbort), .ctl(ctl), .arbReq(arbReq), .busy(busy)
  );

  conn_io_dp #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .destId(destId),
    .setAck(setAck), .setAtn(setAtn), .setTarget(setTarget),
    .jumpAddr(jumpAddr), .scriptPtr(scriptPtr), .targetId(targetId),
    .fetchAddr(fetchAddr), .fetchStb(fetchStb), .done(done),
    .modeUpd(modeUpd), .modeTarget(modeTarget), .latchAck(latchAck),
    .latchAtn(latchAtn), .busDrive(busDrive), .savedJump(savedJump)
  );

  // R3: selection during arbitration branches to the jump address
  assert_sel_jump_R3: assert property (@(posedge clk) disable iff (!rstN)
    (arbReq && (selected || reselected)) |=> (fetchStb && fetchAddr == savedJump));

  // R4: being selected reports target mode
  assert_sel_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && selected && !(cpuAbort && !arbReq)) |=> (modeUpd && modeTarget));

  // R7: abort during wait select branches with no mode change
  assert_abort_jump_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !arbReq && cpuAbort) |=> (fetchStb && !modeUpd && fetchAddr == savedJump));

endmodule

// File: tb/conn_io_sequencer_tb.sv
module conn_io_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int ID_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] opcode = '0;
  logic [ID_W-1:0] destId = '0;
  logic setAck = 0, setAtn = 0, setTarget = 0;
  logic [ADDR_W-1:0] jumpAddr = '0, scriptPtr = '0;
  logic arbWon = 0, selected = 0, reselected = 0, cpuAbort = 0;
  logic arbReq, busy, fetchStb, done, modeUpd, modeTarget, latchAck, latchAtn, busDrive;
  logic [ID_W-1:0] targetId;
  logic [ADDR_W-1:0] fetchAddr;

  int total = 0;
  int bad = 0;
  bit expMode = 0, expAck = 0, expAtn = 0, expDrive = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conn_io_sequencer #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .destId(destId),
    .setAck(setAck), .setAtn(setAtn), .setTarget(setTarget),
    .jumpAddr(jumpAddr), .scriptPtr(scriptPtr), .arbWon(arbWon),
    .selected(selected), .reselected(reselected), .cpuAbort(cpuAbort),
    .arbReq(arbReq), .busy(busy), .targetId(targetId), .fetchAddr(fetchAddr),
    .fetchStb(fetchStb), .done(done), .modeUpd(modeUpd), .modeTarget(modeTarget),
    .latchAck(latchAck), .latchAtn(latchAtn), .busDrive(busDrive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expResel(bit sel, bit rsl, logic [31:0] j, logic [31:0] p);
    return (sel || rsl) ? j : p;
  endfunction

  function automatic logic [31:0] expWsel(bit ab, bit sel, logic [31:0] j, logic [31:0] p);
    if (ab) return j;
    return sel ? p : j;
  endfunction

  task automatic checkState(input string req);
    chk({req, " modeTarget"}, modeTarget, expMode);
    chk({req, " latchAck"}, latchAck, expAck);
    chk({req, " latchAtn"}, latchAtn, expAtn);
    chk({req, " busDrive"}, busDrive, expDrive);
  endtask

  task automatic launch(input logic [1:0] op, input logic [ID_W-1:0] id,
                        input bit a, input bit t, input bit tg,
                        input logic [31:0] j, input logic [31:0] p);
    @(negedge clk);
    opcode = op; destId = id; setAck = a; setAtn = t; setTarget = tg;
    jumpAddr = j; scriptPtr = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0; setAck = 0; setAtn = 0; setTarget = 0;
  endtask

  task automatic afterPulse(input string req);
    @(negedge clk);
    chk({req, " strobe drops"}, fetchStb, 1'b0);
    chk({req, " done drops"}, done, 1'b0);
    chk({req, " idle"}, busy, 1'b0);
  endtask

  // Reselect: k quiet cycles, then an event set
  task automatic runResel(input logic [ID_W-1:0] id, input logic [31:0] j,
                          input logic [31:0] p, input int k,
                          input bit w, input bit s, input bit r);
    launch(2'b00, id, 0, 0, 0, j, p);
    chk("R1 arbReq", arbReq, 1'b1);
    chk("R1 targetId", targetId, id);
    jumpAddr = ~j; scriptPtr = ~p;   // later changes must not matter
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk("R1 still waiting", {busy, arbReq, fetchStb}, 3'b110);
    end
    arbWon = w; selected = s; reselected = r;
    @(negedge clk);
    arbWon = 0; selected = 0; reselected = 0;
    chk("R2/R3 fetchStb", fetchStb, 1'b1);
    chk("R2/R3 done", done, 1'b1);
    chk(s || r ? "R3 jump addr" : "R2 script addr", fetchAddr, expResel(s, r, j, p));
    chk("R4 modeUpd", modeUpd, s || r);
    if (s || r) expMode = s;
    else expDrive = 1'b1;
    checkState("R2/R3/R4");
    afterPulse("R9 resel");
  endtask

  task automatic runWsel(input logic [31:0] j, input logic [31:0] p, input int k,
                         input bit ab, input bit s, input bit r, input bit w);
    launch(2'b10, 0, 0, 0, 0, j, p);
    chk("R6 waiting", {busy, arbReq}, 2'b10);
    jumpAddr = ~j; scriptPtr = ~p;
    for (int i = 0; i < k; i++) begin
      arbWon = w;   // R6: arbitration is irrelevant here
      @(negedge clk);
      chk("R6 still waiting", {busy, fetchStb}, 2'b10);
    end
    cpuAbort = ab; selected = s; reselected = r; arbWon = w;
    @(negedge clk);
    cpuAbort = 0; selected = 0; reselected = 0; arbWon = 0;
    chk("R6/R7 fetchStb", fetchStb, 1'b1);
    chk(ab ? "R7 abort jump" : "R6 wsel addr", fetchAddr, expWsel(ab, s, j, p));
    chk(ab ? "R7 no modeUpd" : "R4 modeUpd", modeUpd, !ab);
    if (!ab) expMode = s;
    checkState("R6/R7");
    afterPulse("R9 wsel");
  endtask

  task automatic runDisc(input logic [31:0] p);
    launch(2'b01, 0, 0, 0, 0, 32'h0, p);
    chk("R5 fetchStb", fetchStb, 1'b1);
    chk("R5 fetchAddr", fetchAddr, p);
    expAck = 0; expAtn = 0; expDrive = 0;
    checkState("R5");
    afterPulse("R9 disc");
  endtask

  task automatic runSet(input bit a, input bit t, input bit tg, input logic [31:0] p);
    launch(2'b11, 0, a, t, tg, 32'h0, p);
    chk("R8 fetchStb", fetchStb, 1'b1);
    chk("R8 fetchAddr", fetchAddr, p);
    chk("R8 modeUpd", modeUpd, tg);
    expAck |= a; expAtn |= t; if (tg) expMode = 1'b1;
    checkState("R8");
    afterPulse("R9 set");
  endtask

  initial begin
    void'($urandom(5150));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset outputs", {fetchStb, done, modeUpd, arbReq, busy}, 5'b0);
    checkState("R10");
    rstN = 1'b1;

    // directed corners
    runResel(4'hA, 32'hDEAD_0001, 32'h0000_1000, 2, 1, 0, 0);   // R2
    runResel(4'h3, 32'hCAFE_0002, 32'h0000_2000, 0, 1, 1, 0);   // R3 race, selected wins
    runResel(4'h5, 32'hBEEF_0003, 32'h0000_3000, 1, 0, 0, 1);   // R4 initiator
    runWsel(32'h1234_5678, 32'h8765_4320, 1, 1, 1, 1, 1);       // R7 abort beats select
    runWsel(32'h0BAD_F00D, 32'h0000_4000, 0, 0, 1, 1, 1);       // R6 select beats reselect
    runSet(1, 1, 1, 32'h0000_5000);                              // R8
    runDisc(32'h0000_6000);                                      // R5

    // R11: events in idle
    @(negedge clk);
    arbWon = 1; selected = 1; reselected = 1; cpuAbort = 1;
    @(negedge clk);
    arbWon = 0; selected = 0; reselected = 0; cpuAbort = 0;
    chk("R11 idle ignores events", {fetchStb, modeUpd, busy, arbReq}, 4'b0);
    checkState("R11");

    // R9: start while busy is ignored
    launch(2'b00, 4'h7, 0, 0, 0, 32'hAAAA_0000, 32'h5555_0000);
    opcode = 2'b11; setAck = 1; setAtn = 1; setTarget = 1; start = 1;
    @(negedge clk);
    start = 0; setAck = 0; setAtn = 0; setTarget = 0;
    chk("R9 busy start ignored", {fetchStb, modeUpd, latchAck, latchAtn}, {2'b00, expAck, expAtn});
    arbWon = 1;
    @(negedge clk);
    arbWon = 0;
    chk("R9 original op completes", fetchAddr, 32'h5555_0000);
    expDrive = 1;
    checkState("R9");
    afterPulse("R9 busy");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int kind;
      logic [31:0] j, p;
      kind = int'($urandom_range(0, 3));
      j = $urandom; p = $urandom;
      case (kind)
        0: begin
          bit w, s, r;
          w = $urandom_range(0, 1); s = $urandom_range(0, 1); r = $urandom_range(0, 1);
          if (!w && !s && !r) w = 1;
          runResel(ID_W'($urandom), j, p, int'($urandom_range(0, 3)), w, s, r);
        end
        1: runDisc(p);
        2: begin
          bit ab, s, r;
          ab = $urandom_range(0, 1); s = $urandom_range(0, 1); r = $urandom_range(0, 1);
          if (!ab && !s && !r) r = 1;
          runWsel(j, p, int'($urandom_range(0, 3)), ab, s, r, 1'($urandom_range(0, 1)));
        end
        default: runSet(1'($urandom), 1'($urandom), 1'($urandom), p);
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule